// File: doc/BRIEF.md
# Two-Cycle Barrett CRC-32 Step Unit

This unit advances a reflected 32-bit CRC by one chunk of 8, 16 or 32 bits. The caller XORs the next data chunk into the low end of the running CRC and presents that value as the source. The unit returns the updated CRC. It does this with Barrett reduction instead of a bit-serial shift register. One 32x32 carry-less multiplier is used twice. In the first cycle it multiplies the aligned operand by the bit-reversed Barrett constant. In the second cycle it multiplies the reversed intermediate by the low 32 bits of the generator.

Two generators are supported. The standard CRC-32 uses 0x04C11DB7, with reversed Barrett constant 0xF7011641. The Castagnoli CRC-32C uses 0x1EDC6F41, with reversed constant 0xDEA713F1. Initial and final inversion of the CRC are left to the caller.

Top module: `crc_barrett_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid_o` is 0 and `result_o` is 0.
- R2: A `start_i` pulse sampled in an idle cycle makes `valid_o` high in the very next cycle, for exactly one cycle.
- R3: A `start_i` sampled in the cycle where `valid_o` is high is ignored. The next cycle has `valid_o` low, and a start in that next cycle is accepted.
- R4: Whenever `valid_o` is low, `result_o` is zero.
- R5: With `size_i` = 2'b00 (byte) and `castagnoli_i` = 0, the result equals the source shifted right 8 times. At each shift, 0xEDB88320 is XORed in when the bit shifted out is 1.
- R6: With `size_i` = 2'b01 the shift count in that rule is 16. With `size_i` = 2'b10 it is 32. The code 2'b11 is treated as a word (32).
- R7: With `castagnoli_i` = 1, the reflected polynomial in that rule is 0x82F63B78, at every size.
- R8: The source, size and polynomial select are captured when the start is accepted. Changing them during the result cycle has no effect on `result_o`.
- R9: A zero source yields a zero result for every size and polynomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an update (taken only when idle) |
| src_i | input | 32 | Running CRC with the data chunk already XORed into its low bits |
| castagnoli_i | input | 1 | 0: CRC-32 generator, 1: CRC-32C generator |
| size_i | input | 2 | Chunk size: 00 byte, 01 halfword, 10 or 11 word |
| result_o | output | 32 | Updated CRC, valid when `valid_o` is high, zero otherwise |
| valid_o | output | 1 | High for the single cycle that carries the result |

## Verification
The bench uses the default data width of 32. That is the only width for which the two generator constants are defined. This default exposes all six generator and size pairings and the spare size code 11. Random sources are compared with a bit-serial reflected reference. Directed cases cover zero and all-ones sources, a start issued in the result cycle, and inputs changed while the result is presented.

// File: rtl/crc_barrett_pkg.sv
package crc_barrett_pkg;

    localparam int unsigned CRC_W = 32;

    // chunk size codes on size_i
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    // low bits of the generators (leading x^32 term implied)
    localparam logic [CRC_W-1:0] GEN_STD  = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] GEN_CAST = 32'h1EDC_6F41;

    // bit-reversed Barrett constants, floor(x^64 / G) without its top bit
    localparam logic [CRC_W-1:0] MU_REV_STD  = 32'hF701_1641;
    localparam logic [CRC_W-1:0] MU_REV_CAST = 32'hDEA7_13F1;

endpackage

// File: rtl/crc_bitrev.sv
module crc_bitrev #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign out_o[i] = in_i[W-1-i];
    end

endmodule

// File: rtl/crc_clmul_lo.sv
// Low half of a W x W carry-less product.
module crc_clmul_lo #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] p_o
);

    logic [W-1:0] acc [W+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_term
        assign acc[i+1] = acc[i] ^ (b_i[i] ? (a_i << i) : '0);
    end

    assign p_o = acc[W];

endmodule

// File: rtl/crc_barrett_unit.sv
module crc_barrett_unit
    import crc_barrett_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CRC_W-1:0] src_i,
    input  logic             castagnoli_i,
    input  logic [1:0]       size_i,
    output logic [CRC_W-1:0] result_o,
    output logic             valid_o
);

    localparam int unsigned SHW = $clog2(CRC_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CRC_W-1:0] src;
        logic [1:0]       size;
        logic             csel;
        logic [CRC_W-1:0] imd;
    } state_t;

    state_t st_d, st_q;

    logic [CRC_W-1:0] mul_a, mul_b, prod, prod_rev;
    logic [CRC_W-1:0] aligned, tail;
    logic [SHW-1:0]   n_in, n_q;

    function automatic logic [SHW-1:0] chunk_bits(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: chunk_bits = SHW'(8);
            SZ_HALF: chunk_bits = SHW'(16);
            default: chunk_bits = SHW'(CRC_W);
        endcase
    endfunction

    crc_clmul_lo #(.W(CRC_W)) u_mul (
        .a_i (mul_a),
        .b_i (mul_b),
        .p_o (prod)
    );

    crc_bitrev #(.W(CRC_W)) u_rev (
        .in_i  (prod),
        .out_o (prod_rev)
    );

    always_comb begin
        st_d    = st_q;
        n_in    = chunk_bits(size_i);
        n_q     = chunk_bits(st_q.size);
        aligned = (n_in == SHW'(CRC_W)) ? src_i : (src_i << (SHW'(CRC_W) - n_in));
        tail    = (n_q == SHW'(CRC_W)) ? '0 : (st_q.src >> n_q);

        // pass 0 from the ports, pass 1 from the intermediate register
        if (st_q.busy) begin
            mul_a = st_q.imd;
            mul_b = st_q.csel ? GEN_CAST : GEN_STD;
        end else begin
            mul_a = aligned;
            mul_b = castagnoli_i ? MU_REV_CAST : MU_REV_STD;
        end

        if (st_q.busy) begin
            st_d.busy = 1'b0;
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.src  = src_i;
            st_d.size = size_i;
            st_d.csel = castagnoli_i;
            st_d.imd  = prod_rev;
        end

        valid_o  = st_q.busy;
        result_o = st_q.busy ? (prod_rev ^ tail) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/crc_barrett_chk.sv
module crc_barrett_chk
    import crc_barrett_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [CRC_W-1:0] result_o,
    input logic             valid_o
);

    // R2
    start_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !valid_o) |=> valid_o);

    // R2
    valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R3
    valid_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(start_i));

    // R4
    idle_result_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (result_o == '0));

endmodule

bind crc_barrett_unit crc_barrett_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .result_o (result_o),
    .valid_o  (valid_o)
);

// File: tb/sim_crc_barrett_unit.sv
module sim_crc_barrett_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src = '0;
    logic        cast = 1'b0;
    logic [1:0]  size = 2'b00;
    logic [31:0] result;
    logic        valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    crc_barrett_unit u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .src_i        (src),
        .castagnoli_i (cast),
        .size_i       (size),
        .result_o     (result),
        .valid_o      (valid)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] s, input logic c,
                                            input logic [1:0] sz);
        logic [31:0] r = s;
        int n = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        for (int i = 0; i < n; i++) begin
            r = r[0] ? ((r >> 1) ^ (c ? 32'h82F63B78 : 32'hEDB88320)) : (r >> 1);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one update; optionally disturb inputs and re-start during the result cycle
    task automatic run(input string req, input logic [31:0] s, input logic c,
                       input logic [1:0] sz, input bit disturb);
        @(negedge clk);
        start = 1'b1; src = s; cast = c; size = sz;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            src = ~s; cast = ~c; size = sz + 2'b01; start = 1'b1;
            #1;
        end
        check({req, " valid"}, {31'b0, valid}, 32'd1);
        check(req, result, ref_crc(s, c, sz));
        @(negedge clk);
        start = 1'b0;
        check({req, " idle after"}, {31'b0, valid}, 32'd0);
        check({req, " idle result"}, result, 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        void'($urandom(32'h1357_2468));
        // R1
        #1;
        check("R1 valid in reset", {31'b0, valid}, 32'd0);
        check("R1 result in reset", result, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'b0, valid}, 32'd0);
        check("R4 result after reset", result, 32'd0);

        // R9 zero source
        for (int k = 0; k < 6; k++) begin
            run("R9 zero", 32'h0, k[0], 2'(k >> 1), 1'b0);
        end
        // R5 R6 R7 all ones and spare size code
        run("R5 ones byte", 32'hFFFF_FFFF, 1'b0, 2'b00, 1'b0);
        run("R6 ones half", 32'hFFFF_FFFF, 1'b0, 2'b01, 1'b0);
        run("R6 ones word", 32'hFFFF_FFFF, 1'b0, 2'b10, 1'b0);
        run("R6 code 11 as word", 32'h1234_5678, 1'b0, 2'b11, 1'b0);
        run("R7 ones word", 32'hFFFF_FFFF, 1'b1, 2'b10, 1'b0);
        run("R7 single bit byte", 32'h0000_0080, 1'b1, 2'b00, 1'b0);

        // R8 and R3: inputs disturbed and a start issued in the result cycle
        run("R8 R3 disturbed byte", 32'hA5C3_0F96, 1'b0, 2'b00, 1'b1);
        run("R8 R3 disturbed word", 32'h0BAD_F00D, 1'b1, 2'b10, 1'b1);

        // R3: start right after the result cycle is accepted
        @(negedge clk);
        start = 1'b1; src = 32'hCAFE_0001; cast = 1'b0; size = 2'b01;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b1; src = 32'h0000_00FF; cast = 1'b1; size = 2'b00;
        @(negedge clk);
        start = 1'b0;
        check("R3 restart valid", {31'b0, valid}, 32'd1);
        check("R3 restart result", result, ref_crc(32'h0000_00FF, 1'b1, 2'b00));
        @(negedge clk);

        // random sweep of all six variants
        for (int k = 0; k < 240; k++) begin
            logic [31:0] s = $urandom();
            logic        c = 1'($urandom());
            logic [1:0]  z = 2'($urandom_range(0, 2));
            run(c ? "R7 random" : (z == 2'b00 ? "R5 random" : "R6 random"), s, c, z, 1'b0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule